// File: doc/BRIEF.md
# Sample Byte Framer for Serial Link

The framer turns a stream of captured 13-bit channel samples into the 8-bit byte stream that a serial transmitter sends. The top bit of every byte is a type flag. Bytes with that bit clear are framing markers. Bytes with that bit set carry payload. Because each byte can hold only seven payload bits, every sample goes out as two payload bytes.

Samples are grouped into blocks. A block opens with a start marker, and that marker tells raw channel samples apart from bunch samples. The samples of the block follow. The sample flagged as last closes the block. After it, the framer sends a snapshot of the settings vector, split into 7-bit payload chunks, and then an end marker.

On the input side is a valid/ready sample port with a block-kind bit and a last flag. On the output side is a valid/ready byte port that feeds the transmitter. The settings vector is a plain input, and the framer samples it once per block.

Top module: `sample_byte_framer`

## Requirements
- R1: After a synchronous active-low reset, `m_valid` is 0 and `s_ready` is 1.
- R2: The first sample accepted while no block is open opens a new block. The first byte of that block is the start marker: 0x01 when `s_bunch` was 0 at that accept, and 0x03 when it was 1.
- R3: Each sample is sent as two bytes, high part first. The first byte is {1, 0, sample[12:7]} and the second is {1, sample[6:0]}.
- R4: Every byte with bit 7 = 0 is a marker, and its value is one of 0x01, 0x03 or 0x02. Every sample byte and every settings byte has bit 7 = 1.
- R5: `s_ready` is high only when no byte is pending. `s_ready` and `m_valid` are never high in the same cycle.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value. No byte is lost or repeated.
- R7: After the second byte of a sample accepted with `s_last` = 1, the framer sends N_SET settings bytes and then the end marker 0x02. Settings byte k is {1, settings[7k+6:7k]}, sent in order k = 0, 1, 2.
- R8: The settings are snapshotted when the last sample of a block is accepted. Changes to `settings` after that accept do not affect the bytes sent.
- R9: Samples after the first one in a block get no marker before them, and their `s_bunch` value is ignored. After the end marker, the next accepted sample opens a new block with a new start marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | A sample is offered |
| s_ready | output | 1 | The framer accepts the offered sample |
| s_data | input | 13 | Sample value |
| s_bunch | input | 1 | Block kind, used only when the sample opens a block: 1 = bunch, 0 = raw |
| s_last | input | 1 | This sample closes the block |
| settings | input | 21 | Settings vector, sent as three 7-bit chunks |
| m_valid | output | 1 | A byte is offered to the transmitter |
| m_ready | input | 1 | The transmitter takes the byte |
| m_data | output | 8 | Byte value, with bit 7 as the type flag |

## Verification
The first pattern is a raw block with the transmitter always ready. Its samples are all-ones, all-zeros and alternating bits. This shows whether the split lands on bit 7 and whether the flag bits are placed correctly.

The second pattern is a bunch block with the transmitter ready only one cycle in three. The settings change just after the last accept. This separates a correct back-pressure hold and snapshot from a design that skips or repeats bytes, or that reads the settings live.

The third pattern is two blocks back to back, with the kind bit toggled in the middle of the first block. It shows that the kind is latched only when a block opens, and that the block boundary rearms the start marker.

// File: rtl/sbf_pkg.sv
// Shared types and constants for the sample byte framer.
package sbf_pkg;
    localparam int PAY_BITS = 7;

    localparam logic [7:0] MARK_RAW   = 8'h01;
    localparam logic [7:0] MARK_END   = 8'h02;
    localparam logic [7:0] MARK_BUNCH = 8'h03;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_START = 3'd1,
        ST_HI    = 3'd2,
        ST_LO    = 3'd3,
        ST_SET   = 3'd4,
        ST_END   = 3'd5
    } sbf_state_e;
endpackage

// File: rtl/sbf_ctrl.sv
// Sequencer of the framer. Decides which byte is offered and when a
// sample may be taken in.
// Assumes that the downstream side takes a byte on any cycle where
// m_valid and m_ready are both high.
module sbf_ctrl
    import sbf_pkg::*;
#(
    parameter int N_SET = 3,
    localparam int IDX_W = (N_SET > 1) ? $clog2(N_SET) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic             s_last,
    input  logic             m_ready,
    output logic             s_ready,
    output logic             m_valid,
    output logic             open_blk,
    output logic             snap_en,
    output logic             in_blk,
    output sbf_state_e       st,
    output logic [IDX_W-1:0] idx
);
    logic last_q;
    logic accept;

    // Handshake and capture strobes, derived from the current state.
    always_comb begin
        s_ready  = (st == ST_WAIT);
        m_valid  = (st != ST_WAIT);
        accept   = s_valid && s_ready;
        open_blk = accept && !in_blk;
        snap_en  = accept && s_last;
    end

    // Steps through marker, sample halves, settings chunks and end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_WAIT;
            in_blk <= 1'b0;
            last_q <= 1'b0;
            idx    <= '0;
        end else begin
            case (st)
                ST_WAIT: if (s_valid) begin
                    last_q <= s_last;
                    in_blk <= 1'b1;
                    st     <= in_blk ? ST_HI : ST_START;
                end
                ST_START: if (m_ready) st <= ST_HI;
                ST_HI:    if (m_ready) st <= ST_LO;
                ST_LO: if (m_ready) begin
                    if (last_q) begin
                        st  <= ST_SET;
                        idx <= '0;
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                ST_SET: if (m_ready) begin
                    if (idx == IDX_W'(N_SET - 1)) st <= ST_END;
                    else idx <= idx + 1'b1;
                end
                ST_END: if (m_ready) begin
                    st     <= ST_WAIT;
                    in_blk <= 1'b0;
                end
                default: st <= ST_WAIT;
            endcase
        end
    end

    // R5: no sample is taken while a byte is being offered.
    a_r5_wait_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_WAIT) |=> ((st == ST_WAIT) || !$changed(last_q)));
endmodule

// File: rtl/sbf_set_snap.sv
// Holds the settings snapshot and selects the 7-bit chunk for the
// current index.
// Assumes that snap_en pulses once, on the accept of a last sample.
module sbf_set_snap
    import sbf_pkg::*;
#(
    parameter int N_SET = 3,
    localparam int SET_W = N_SET * PAY_BITS,
    localparam int IDX_W = (N_SET > 1) ? $clog2(N_SET) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snap_en,
    input  logic [SET_W-1:0]    settings,
    input  logic [IDX_W-1:0]    idx,
    output logic [PAY_BITS-1:0] chunk
);
    logic [PAY_BITS-1:0] part [N_SET];

    // One register per chunk, loaded together on the snapshot strobe.
    for (genvar k = 0; k < N_SET; k++) begin : g_part
        always_ff @(posedge clk) begin
            if (!rst_n)       part[k] <= '0;
            else if (snap_en) part[k] <= settings[k*PAY_BITS +: PAY_BITS];
        end
    end

    // Chunk selection; indices beyond the count read as zero.
    always_comb begin
        chunk = '0;
        for (int k = 0; k < N_SET; k++)
            if (idx == IDX_W'(k)) chunk = part[k];
    end

    // R8: the snapshot changes only on the strobe.
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(part[0]));
endmodule

// File: rtl/sbf_byte_form.sv
// Holds the accepted sample and the block kind, and forms the outgoing
// byte from the sequencer state.
// Assumes that SMP_W - 7 is at most 6, so the high part fits under the
// flag bits.
module sbf_byte_form
    import sbf_pkg::*;
#(
    parameter int SMP_W = 13,
    localparam int HI_W = SMP_W - PAY_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                open_blk,
    input  logic [SMP_W-1:0]    s_data,
    input  logic                s_bunch,
    input  sbf_state_e          st,
    input  logic [PAY_BITS-1:0] chunk,
    output logic [7:0]          byte_o
);
    logic [SMP_W-1:0] smp;
    logic             kind;

    // Sample captured on every accept; kind captured only when a block opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp  <= '0;
            kind <= 1'b0;
        end else begin
            if (accept)   smp  <= s_data;
            if (open_blk) kind <= s_bunch;
        end
    end

    // Byte formation for each state.
    always_comb begin
        byte_o = 8'h00;
        case (st)
            ST_START: byte_o = kind ? MARK_BUNCH : MARK_RAW;
            ST_HI:    byte_o = {2'b10, (6)'(smp[SMP_W-1 -: HI_W])};
            ST_LO:    byte_o = {1'b1, smp[PAY_BITS-1:0]};
            ST_SET:   byte_o = {1'b1, chunk};
            ST_END:   byte_o = MARK_END;
            default:  byte_o = 8'h00;
        endcase
    end

    // R3: the high-part byte leaves bit 6 clear.
    a_r3_hi_bit6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HI) |-> (byte_o[7:6] == 2'b10));
endmodule

// File: rtl/sample_byte_framer.sv
// Top of the sample byte framer. Wraps samples in marked blocks of
// flagged bytes, then appends a settings snapshot and an end marker.
// Assumes a single clock domain and a downstream side that uses a
// valid/ready handshake.
module sample_byte_framer
    import sbf_pkg::*;
#(
    parameter int SMP_W = 13,
    parameter int N_SET = 3,
    localparam int SET_W = N_SET * PAY_BITS,
    localparam int IDX_W = (N_SET > 1) ? $clog2(N_SET) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [SMP_W-1:0] s_data,
    input  logic             s_bunch,
    input  logic             s_last,
    input  logic [SET_W-1:0] settings,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data
);
    sbf_state_e          st;
    logic [IDX_W-1:0]    idx;
    logic                open_blk, snap_en, in_blk;
    logic [PAY_BITS-1:0] chunk;

    sbf_ctrl #(.N_SET(N_SET)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_last(s_last),
        .m_ready(m_ready), .s_ready(s_ready), .m_valid(m_valid),
        .open_blk(open_blk), .snap_en(snap_en), .in_blk(in_blk),
        .st(st), .idx(idx)
    );

    sbf_set_snap #(.N_SET(N_SET)) u_snap (
        .clk(clk), .rst_n(rst_n), .snap_en(snap_en), .settings(settings),
        .idx(idx), .chunk(chunk)
    );

    sbf_byte_form #(.SMP_W(SMP_W)) u_form (
        .clk(clk), .rst_n(rst_n), .accept(s_valid && s_ready),
        .open_blk(open_blk), .s_data(s_data), .s_bunch(s_bunch),
        .st(st), .chunk(chunk), .byte_o(m_data)
    );

    // R5: the framer never takes a sample and offers a byte together.
    a_r5_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && m_valid));

    // R6: a stalled byte is held unchanged.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R4: every byte with the flag clear is one of the three markers.
    a_r4_marker_set: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_data[7]) |->
            (m_data == MARK_RAW || m_data == MARK_BUNCH || m_data == MARK_END));

    // R2: opening a block puts a start marker on the output first.
    a_r2_open_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !in_blk) |=>
            (m_valid && (m_data == MARK_RAW || m_data == MARK_BUNCH)));

    // R9: a sample inside an open block goes straight to payload.
    a_r9_cont_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && in_blk) |=> (m_valid && m_data[7]));

    // R7: once the end marker is taken, the input reopens.
    a_r7_end_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_data == MARK_END) |=> s_ready);
endmodule

// File: tb/sample_byte_framer_test.sv
module sample_byte_framer_test;
    localparam int SMP_W = 13;
    localparam int N_SET = 3;
    localparam int SET_W = N_SET * 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [SMP_W-1:0] s_data = '0;
    logic             s_bunch = 1'b0;
    logic             s_last = 1'b0;
    logic [SET_W-1:0] settings = '0;
    logic             m_valid;
    logic             m_ready = 1'b1;
    logic [7:0]       m_data;

    int checks = 0;
    int errors = 0;
    int bp_mode = 0;
    int cyc = 0;
    int excl_bad = 0;
    int hold_bad = 0;
    int hold_seen = 0;
    bit done = 0;
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];

    sample_byte_framer #(.SMP_W(SMP_W), .N_SET(N_SET)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_bunch(s_bunch), .s_last(s_last),
        .settings(settings), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data)
    );

    always #5 clk = ~clk;

    // Downstream ready pattern, driven just after each rising edge.
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        m_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    end

    // Monitor at the falling edge: records handshakes and checks R5 and R6.
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (s_ready && m_valid) excl_bad++;
            if (prev_stall) begin
                hold_seen++;
                if (!m_valid || m_data != prev_data) hold_bad++;
            end
            if (m_valid && m_ready) got_q.push_back(m_data);
            prev_stall = m_valid && !m_ready;
            prev_data  = m_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [12:0] d, input logic b, input logic l);
        @(posedge clk); #1;
        s_valid = 1'b1; s_data = d; s_bunch = b; s_last = l;
        do @(negedge clk); while (!s_ready);
        @(posedge clk); #1;
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic exp_sample(input logic [12:0] d);
        exp_q.push_back({2'b10, d[12:7]});
        exp_q.push_back({1'b1, d[6:0]});
    endtask

    task automatic exp_tail(input logic [SET_W-1:0] s);
        for (int k = 0; k < N_SET; k++) exp_q.push_back({1'b1, s[k*7 +: 7]});
        exp_q.push_back(8'h02);
    endtask

    task automatic drain_compare(input string req);
        int t = 0;
        while (got_q.size() < exp_q.size() && t < 2000) begin
            @(negedge clk); t++;
        end
        repeat (10) @(negedge clk);
        check({req, " count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++)
            check(req, (i < got_q.size()) ? got_q[i] : 8'hxx, exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    // R1: reset state.
    task automatic t_reset();
        @(negedge clk);
        check("R1 m_valid", m_valid, 1'b0);
        check("R1 s_ready", s_ready, 1'b1);
    endtask

    // R2 R3 R4 R7: raw block, no back-pressure, edge sample values.
    task automatic t_raw();
        bp_mode = 0;
        settings = 21'h0ABCDE;
        exp_q.push_back(8'h01);
        put(13'h1FFF, 1'b0, 1'b0); exp_sample(13'h1FFF);
        put(13'h0000, 1'b0, 1'b0); exp_sample(13'h0000);
        put(13'h1555, 1'b0, 1'b1); exp_sample(13'h1555);
        exp_tail(21'h0ABCDE);
        drain_compare("R2 R3 R7 raw");
    endtask

    // R2 R6 R8: bunch block under back-pressure; settings change after the last accept.
    task automatic t_bunch_bp();
        bp_mode = 1;
        settings = 21'h12345;
        exp_q.push_back(8'h03);
        put(13'h0AAA, 1'b1, 1'b0); exp_sample(13'h0AAA);
        put(13'h0080, 1'b1, 1'b1); exp_sample(13'h0080);
        settings = 21'h1FFFFF;
        exp_tail(21'h12345);
        drain_compare("R6 R8 bunch");
        bp_mode = 0;
    endtask

    // R9: kind toggled mid-block is ignored; the next block gets a new marker.
    task automatic t_two_blocks();
        settings = 21'h07F00;
        exp_q.push_back(8'h01);
        put(13'h0123, 1'b0, 1'b0); exp_sample(13'h0123);
        put(13'h1F80, 1'b1, 1'b1); exp_sample(13'h1F80);
        exp_tail(21'h07F00);
        exp_q.push_back(8'h03);
        put(13'h007F, 1'b1, 1'b1); exp_sample(13'h007F);
        exp_tail(21'h07F00);
        drain_compare("R9 two blocks");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_raw();
        t_bunch_bp();
        t_two_blocks();
        check("R5 ready/valid overlap", excl_bad, 0);
        check("R6 stall hold", hold_bad, 0);
        check("R6 stalls observed", (hold_seen > 0), 1'b1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(100000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule